// File: doc/BRIEF.md
# Processor Presence Bitmap

This block holds a bitmap of 256 processor slots, one bit for each processor ID. Firmware reads it one byte at a time through a 32-byte window. At reset the block loads the bitmap from a boot-time presence vector, so processors that are already fitted show as present from the first read.

The platform side sends add and remove requests, each carrying a processor ID. An add sets that processor's bit and a remove clears it. Every request that is accepted also latches the processor-event bit (bit 2) of an event status byte. Firmware uses that bit to learn that it should rescan the window, and pulses an acknowledge input to clear it.

A request whose ID is outside the bitmap is dropped, and it raises a sticky error flag. Software writes to the window are accepted and have no effect.

Top module: `cpu_presence_map`

## Requirements
- R1: While `rst_n` is low, the bitmap is loaded from `boot_present`, and `evt_status` and `id_err` are cleared.
- R2: Processor ID n maps to bit (n mod 8) of the byte at window address n/8. Window address a returns bitmap bits 8a+7 down to 8a.
- R3: An accepted request with `req_add`=1 sets the mapped bit and leaves every other bit unchanged. Adding a processor that is already present leaves the bitmap as it was.
- R4: An accepted request with `req_add`=0 clears the mapped bit and leaves every other bit unchanged.
- R5: Every accepted request sets bit 2 of `evt_status` on the next clock edge. Bits 7..3 and 1..0 of `evt_status` are always zero.
- R6: A cycle with `evt_ack` high clears bit 2 of `evt_status`. If an accepted request arrives in the same cycle, the bit is set instead.
- R7: A request with `req_id` of 256 or more is dropped. The bitmap does not change, no event is raised, and `id_err` goes high and stays high until reset.
- R8: When `rd_en` is high, `rd_data` takes the addressed byte as it stood before that clock edge. The new value appears one cycle later. When `rd_en` is low, `rd_data` holds its value. Reads change no state.
- R9: When `wr_en` is high, the window accepts the write and ignores it. The bitmap, `evt_status` and `id_err` are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset; loads the boot vector |
| boot_present | input | 256 | Boot-time presence vector, bit n for processor n |
| req_valid | input | 1 | Request strobe |
| req_add | input | 1 | 1 = add, 0 = remove |
| req_id | input | 9 | Processor ID of the request |
| evt_ack | input | 1 | Clears the processor-event status bit |
| rd_en | input | 1 | Window read strobe |
| wr_en | input | 1 | Window write strobe (ignored) |
| addr | input | 5 | Window byte address |
| wr_data | input | 8 | Write data (ignored) |
| rd_data | output | 8 | Registered read data |
| evt_status | output | 8 | Event status byte; bit 2 is the processor event |
| id_err | output | 1 | Sticky flag for an out-of-range request |

## Verification
Two pairs of functions can land on the same clock edge, and the bench drives each pair deliberately.

In the first pair, a request is issued together with an event acknowledge. The bench judges this by checking that bit 2 of `evt_status` is still set afterwards.

In the second pair, a request is issued together with a read of the byte it changes. The bench checks that this read returns the old byte, then reads again and checks that the second read shows the update.

// File: rtl/cpu_presence_map.sv
module cpu_presence_map #(
  parameter int NBYTES  = 32,
  parameter int ID_W    = 9,
  parameter int EVT_BIT = 2,
  localparam int NBITS  = NBYTES * 8,
  localparam int AW     = $clog2(NBYTES),
  localparam int IW     = $clog2(NBITS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NBITS-1:0] boot_present,
  input  logic             req_valid,
  input  logic             req_add,
  input  logic [ID_W-1:0]  req_id,
  input  logic             evt_ack,
  input  logic             rd_en,
  input  logic             wr_en,
  input  logic [AW-1:0]    addr,
  input  logic [7:0]       wr_data,
  output logic [7:0]       rd_data,
  output logic [7:0]       evt_status,
  output logic             id_err
);

  logic [NBITS-1:0] map_q;
  logic             evt_q;
  logic             in_range;
  logic             accept;
  logic [IW-1:0]    idx;
  logic             unused_wr;

  assign in_range  = ({{(32-ID_W){1'b0}}, req_id} < NBITS);
  assign accept    = req_valid && in_range;
  assign idx       = req_id[IW-1:0];
  assign unused_wr = ^{wr_en, wr_data};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      map_q <= boot_present;
    end else if (accept) begin
      map_q[idx] <= req_add;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      evt_q  <= 1'b0;
      id_err <= 1'b0;
    end else begin
      if (accept)         evt_q <= 1'b1;
      else if (evt_ack)   evt_q <= 1'b0;
      if (req_valid && !in_range) id_err <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)     rd_data <= 8'h00;
    else if (rd_en) rd_data <= map_q[addr*8 +: 8];
  end

  always_comb begin
    evt_status          = 8'h00;
    evt_status[EVT_BIT] = evt_q;
  end

endmodule

module cpu_presence_map_chk #(
  parameter int ID_W  = 9,
  parameter int NBITS = 256
) (
  input logic            clk,
  input logic            rst_n,
  input logic            req_valid,
  input logic [ID_W-1:0] req_id,
  input logic            evt_ack,
  input logic            rd_en,
  input logic [7:0]      rd_data,
  input logic [7:0]      evt_status,
  input logic            id_err
);
  logic big;
  assign big = ({{(32-ID_W){1'b0}}, req_id} >= NBITS);

  assert_evt_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !big |=> evt_status[2]);
  assert_evt_mask_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_status & 8'hFB) == 8'h00);
  assert_evt_ack_R6: assert property (@(posedge clk) disable iff (!rst_n)
    evt_ack && !req_valid |=> !evt_status[2]);
  assert_bad_id_R7: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && big |=> id_err);
  assert_err_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    id_err |=> id_err);
  assert_bad_no_evt_R7: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && big && !evt_status[2] |=> !evt_status[2]);
  assert_rd_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rd_data));
endmodule

bind cpu_presence_map cpu_presence_map_chk #(.ID_W(ID_W), .NBITS(NBITS)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_id(req_id),
  .evt_ack(evt_ack), .rd_en(rd_en), .rd_data(rd_data),
  .evt_status(evt_status), .id_err(id_err)
);

// File: tb/cpu_presence_map_tb.sv
`timescale 1ns/1ps
module cpu_presence_map_tb;
  logic         clk = 0;
  logic         rst_n = 0;
  logic [255:0] boot_present;
  logic         req_valid = 0, req_add = 0, evt_ack = 0, rd_en = 0, wr_en = 0;
  logic [8:0]   req_id = '0;
  logic [4:0]   addr = '0;
  logic [7:0]   wr_data = '0;
  logic [7:0]   rd_data, evt_status;
  logic         id_err;
  logic [255:0] model;
  int total = 0, bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  cpu_presence_map u_dut (
    .clk(clk), .rst_n(rst_n), .boot_present(boot_present),
    .req_valid(req_valid), .req_add(req_add), .req_id(req_id),
    .evt_ack(evt_ack), .rd_en(rd_en), .wr_en(wr_en), .addr(addr),
    .wr_data(wr_data), .rd_data(rd_data), .evt_status(evt_status),
    .id_err(id_err)
  );

  // {add, id}
  localparam logic [9:0] VEC [8] = '{
    {1'b1, 9'd10}, {1'b1, 9'd255}, {1'b0, 9'd1}, {1'b1, 9'd8},
    {1'b0, 9'd255}, {1'b1, 9'd0}, {1'b0, 9'd100}, {1'b1, 9'd31}
  };

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  task automatic rd(input logic [4:0] a);
    @(negedge clk); rd_en = 1; addr = a;
    @(negedge clk); rd_en = 0;
  endtask

  task automatic req(input logic add, input logic [8:0] id);
    @(negedge clk); req_valid = 1; req_add = add; req_id = id;
    @(negedge clk); req_valid = 0;
    if (id < 256) model[id[7:0]] = add;
  endtask

  task automatic ack();
    @(negedge clk); evt_ack = 1;
    @(negedge clk); evt_ack = 0;
  endtask

  task automatic do_reset();
    rst_n = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
    model = boot_present;
  endtask

  initial begin
    boot_present = '0;
    boot_present[3:0] = 4'hF;
    boot_present[200] = 1'b1;
    do_reset();
    chk("R1 evt", {24'h0, evt_status}, 32'h0);
    chk("R1 err", {31'h0, id_err}, 32'h0);
    for (int a = 0; a < 32; a++) begin
      rd(a[4:0]);
      chk("R1 R2 boot byte", {24'h0, rd_data}, {24'h0, model[a*8 +: 8]});
    end

    for (int i = 0; i < 8; i++) begin
      req(VEC[i][9], VEC[i][8:0]);
      chk("R5 evt set", {24'h0, evt_status}, 32'h4);
      rd(VEC[i][7:3]);
      chk(VEC[i][9] ? "R3 add" : "R4 remove", {24'h0, rd_data},
          {24'h0, model[VEC[i][7:3]*8 +: 8]});
      ack();
      chk("R6 ack clears", {24'h0, evt_status}, 32'h0);
    end

    // R2 explicit mapping: id 77 -> byte 9 bit 5
    req(1'b1, 9'd77); ack();
    rd(5'd9);
    chk("R2 id77 byte9 bit5", {24'h0, rd_data}, 32'h20);

    // R9 writes ignored
    @(negedge clk); wr_en = 1; addr = 5'd9; wr_data = 8'hFF;
    @(negedge clk); wr_en = 0;
    rd(5'd9);
    chk("R9 write ignored", {24'h0, rd_data}, 32'h20);
    chk("R9 evt untouched", {24'h0, evt_status}, 32'h0);
    chk("R9 err untouched", {31'h0, id_err}, 32'h0);

    // R8 read repeat, no side effect, hold when idle
    rd(5'd0);
    chk("R8 read a", {24'h0, rd_data}, {24'h0, model[7:0]});
    rd(5'd0);
    chk("R8 read b", {24'h0, rd_data}, {24'h0, model[7:0]});
    repeat (3) @(negedge clk);
    chk("R8 hold", {24'h0, rd_data}, {24'h0, model[7:0]});

    // R7 out of range
    req(1'b1, 9'd256);
    chk("R7 err set", {31'h0, id_err}, 32'h1);
    chk("R7 no evt", {24'h0, evt_status}, 32'h0);
    rd(5'd0);
    chk("R7 map unchanged", {24'h0, rd_data}, {24'h0, model[7:0]});
    req(1'b0, 9'd300);
    repeat (3) @(negedge clk);
    chk("R7 sticky", {31'h0, id_err}, 32'h1);

    // R6 request and ack in the same cycle: set wins
    @(negedge clk); req_valid = 1; req_add = 1; req_id = 9'd50; evt_ack = 1;
    @(negedge clk); req_valid = 0; evt_ack = 0; model[50] = 1'b1;
    chk("R6 set wins", {24'h0, evt_status}, 32'h4);

    // R8 read and update of same byte in same cycle: old then new
    @(negedge clk); req_valid = 1; req_add = 1; req_id = 9'd52; rd_en = 1; addr = 5'd6;
    @(negedge clk); req_valid = 0; rd_en = 0;
    chk("R8 pre-update read", {24'h0, rd_data}, {24'h0, model[55:48]});
    model[52] = 1'b1;
    rd(5'd6);
    chk("R8 post-update read", {24'h0, rd_data}, {24'h0, model[55:48]});

    // R1 second reset reloads a new boot vector and clears flags
    boot_present = '0;
    boot_present[255] = 1'b1;
    do_reset();
    chk("R1 err cleared", {31'h0, id_err}, 32'h0);
    chk("R1 evt cleared", {24'h0, evt_status}, 32'h0);
    rd(5'd31);
    chk("R1 reload top", {24'h0, rd_data}, 32'h80);
    rd(5'd0);
    chk("R1 reload low", {24'h0, rd_data}, 32'h0);

    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule